// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block is a memory-mapped general-purpose I/O peripheral. It drives and samples a parameterised number of 32-pin groups (two by default, 64 pins in all). Software reaches it through a plain word-addressed register bus. For each group it can do the following:
- choose per pin whether the pin drives or only listens;
- load, set or clear output bits without a read-modify-write;
- read the synchronised pad level;
- arm rising-edge and falling-edge detection per pin.

Detected edges latch into a status word that software clears by writing ones to it.

Every 32-pin group feeds two interrupt lines, one for its low 16 pins and one for its high 16 pins. Line n belongs to group n/2: its low half when n is even, its high half when n is odd. The software handler therefore finds a pin's interrupt number as (line/2)*32 plus the bit position. A global line-enable word gates every line. The bus has no handshake: a write takes effect at the clock edge that samples `bus_we`, and read data is combinational on `bus_addr`.

Word addresses follow. Byte offsets are four times these values.
- Line-enable word: word 2.
- Group g: a block of ten words starting at word 4 + 10*g, at these indices:
  - 0 direction
  - 1 output load
  - 2 output set
  - 3 output clear
  - 4 input level
  - 5 rising arm
  - 6 rising disarm
  - 7 falling arm
  - 8 falling disarm
  - 9 status

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every pin is an input (`pin_oe` all 0), `pin_out` is 0, all edge arms and status bits are 0, the line-enable word is 0 and `bank_irq` is 0. The direction word reads all ones.
- R2: A 1 in the direction word (index 0) makes the pin an input, so its `pin_oe` bit is 0. A 0 makes it an output, so its `pin_oe` bit is 1. The new direction takes effect one clock after the write.
- R3: A write to index 1 loads the output word. A 1 bit written to index 2 drives that output high and a 1 bit written to index 3 drives it low. Zero bits leave outputs unchanged, and indices 1, 2 and 3 all read back the output word.
- R4: Index 4 returns the pad level through a two-flop synchroniser, whatever the pin's direction. A pad change becomes readable after the second rising clock edge and not before.
- R5: Writing ones to index 5 or 7 arms the rising or falling detection for those pins. Writing ones to index 6 or 8 disarms them, and zero bits change nothing. Both words of a pair read back the current arm mask.
- R6: A status bit (index 9) sets on the third clock edge after an armed edge reaches the pad, comparing the synchronised level with its value one clock earlier. Unarmed edges set nothing.
- R7: Writing ones to the status word clears those bits. If a new armed edge on a bit lands in the same cycle as a clear of that bit, the bit stays set.
- R8: `bank_irq[n]` is high exactly while some status bit in half n%2 of group n/2 is set and bit n of the line-enable word (word 2) is 1.
- R9: Reads of unmapped words (0, 1, 3, and every word past the last group) return 0. Writes to them change no output, no interrupt line and no register.
- R10: Group g's words start at 4 + 10*g and act only on pins 32*g to 32*g+31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (6) | Word address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pin_in | input | 32*NUM_SETS (64) | Pad levels, asynchronous |
| pin_out | output | 32*NUM_SETS (64) | Output data to pads |
| pin_oe | output | 32*NUM_SETS (64) | Output enable per pin, 1 = driving |
| bank_irq | output | 2*NUM_SETS (4) | One interrupt line per 16-pin half |

## Verification
A corrupted output, direction or arm register shows at the pins, or in the read data, one clock after the write that should have shaped it. A wrong line-enable or status bit shows on `bank_irq` in the same cycle it goes wrong. Edge-detector state errors are subtler: a stale previous-level flop shows as a missing or extra status bit on the third clock after a pad change. The bench therefore samples each edge case exactly at that cycle. It also drives a clear into the very cycle an edge is detected, because that collision is the one place where the status update order matters.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned GRP_W      = 32;
  localparam int unsigned HALF_W     = GRP_W / 2;
  localparam int unsigned IRQ_EN_WRD = 2;
  localparam int unsigned GRP_BASE   = 4;
  localparam int unsigned GRP_STRIDE = 10;
  localparam int unsigned IDX_W      = 4;

  typedef enum logic [IDX_W-1:0] {
    IX_DIR    = 4'd0,
    IX_LOAD   = 4'd1,
    IX_SET    = 4'd2,
    IX_CLR    = 4'd3,
    IX_LEVEL  = 4'd4,
    IX_RARM   = 4'd5,
    IX_RDIS   = 4'd6,
    IX_FARM   = 4'd7,
    IX_FDIS   = 4'd8,
    IX_STAT   = 4'd9
  } grp_idx_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= async_in;
      stab_q <= meta_q;
    end
  end

  assign sync_out = stab_q;
endmodule

// File: rtl/gpio_group.sv
module gpio_group
  import gpio_bank_pkg::*;
#(
  parameter int unsigned W = GRP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic [IDX_W-1:0] idx,
  input  logic             we,
  input  logic [W-1:0]     wdata,
  input  logic [W-1:0]     pad_in,
  output logic [W-1:0]     rdata,
  output logic [W-1:0]     dout,
  output logic [W-1:0]     oe,
  output logic [W-1:0]     stat
);
  logic [W-1:0] dir_q, out_q, rarm_q, farm_q, stat_q, prev_q;
  logic [W-1:0] level;
  logic [W-1:0] hits;
  logic         wr;

  gpio_sync #(.W(W)) sync_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pad_in),
    .sync_out (level)
  );

  assign wr   = sel && we;
  assign hits = (level & ~prev_q & rarm_q) | (~level & prev_q & farm_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '1;
      out_q  <= '0;
      rarm_q <= '0;
      farm_q <= '0;
      stat_q <= '0;
      prev_q <= '0;
    end else begin
      prev_q <= level;
      if (wr && idx == IX_DIR)  dir_q <= wdata;
      if (wr && idx == IX_LOAD) out_q <= wdata;
      else if (wr && idx == IX_SET) out_q <= out_q | wdata;
      else if (wr && idx == IX_CLR) out_q <= out_q & ~wdata;
      if (wr && idx == IX_RARM) rarm_q <= rarm_q | wdata;
      else if (wr && idx == IX_RDIS) rarm_q <= rarm_q & ~wdata;
      if (wr && idx == IX_FARM) farm_q <= farm_q | wdata;
      else if (wr && idx == IX_FDIS) farm_q <= farm_q & ~wdata;
      if (wr && idx == IX_STAT) stat_q <= (stat_q & ~wdata) | hits;
      else stat_q <= stat_q | hits;
    end
  end

  always_comb begin
    rdata = '0;
    if (sel) begin
      case (idx)
        IX_DIR:                   rdata = dir_q;
        IX_LOAD, IX_SET, IX_CLR:  rdata = out_q;
        IX_LEVEL:                 rdata = level;
        IX_RARM, IX_RDIS:         rdata = rarm_q;
        IX_FARM, IX_FDIS:         rdata = farm_q;
        IX_STAT:                  rdata = stat_q;
        default:                  rdata = '0;
      endcase
    end
  end

  assign dout = out_q;
  assign oe   = ~dir_q;
  assign stat = stat_q;
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_SETS = 2,
  parameter int unsigned ADDR_W   = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [31:0]               bus_wdata,
  input  logic                      bus_we,
  output logic [31:0]               bus_rdata,
  input  logic [GRP_W*NUM_SETS-1:0] pin_in,
  output logic [GRP_W*NUM_SETS-1:0] pin_out,
  output logic [GRP_W*NUM_SETS-1:0] pin_oe,
  output logic [2*NUM_SETS-1:0]     bank_irq
);
  localparam int unsigned NB = 2 * NUM_SETS;

  logic [NB-1:0]               irq_en_q;
  logic [GRP_W*NUM_SETS-1:0]   stat_all;
  logic [NUM_SETS-1:0][31:0]   grp_rdata;
  logic                        en_hit;

  assign en_hit = (bus_addr == ADDR_W'(IRQ_EN_WRD));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                irq_en_q <= '0;
    else if (bus_we && en_hit) irq_en_q <= bus_wdata[NB-1:0];
  end

  for (genvar g = 0; g < NUM_SETS; g++) begin : g_grp
    localparam int unsigned BASE = GRP_BASE + GRP_STRIDE * g;
    logic [ADDR_W-1:0] off;
    logic              hit;

    assign off = bus_addr - ADDR_W'(BASE);
    assign hit = (bus_addr >= ADDR_W'(BASE)) && (off < ADDR_W'(GRP_STRIDE));

    gpio_group #(.W(GRP_W)) grp_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel    (hit),
      .idx    (off[IDX_W-1:0]),
      .we     (bus_we),
      .wdata  (bus_wdata),
      .pad_in (pin_in[g*GRP_W +: GRP_W]),
      .rdata  (grp_rdata[g]),
      .dout   (pin_out[g*GRP_W +: GRP_W]),
      .oe     (pin_oe[g*GRP_W +: GRP_W]),
      .stat   (stat_all[g*GRP_W +: GRP_W])
    );
  end

  for (genvar b = 0; b < NB; b++) begin : g_line
    assign bank_irq[b] = irq_en_q[b] && (|stat_all[(b/2)*GRP_W + (b%2)*HALF_W +: HALF_W]);
  end

  always_comb begin
    bus_rdata = en_hit ? 32'(irq_en_q) : 32'd0;
    for (int g = 0; g < NUM_SETS; g++) bus_rdata = bus_rdata | grp_rdata[g];
  end
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_SETS = 2,
  parameter int unsigned ADDR_W   = 6
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [ADDR_W-1:0]         bus_addr,
  input logic [31:0]               bus_wdata,
  input logic                      bus_we,
  input logic [GRP_W*NUM_SETS-1:0] pin_out,
  input logic [GRP_W*NUM_SETS-1:0] pin_oe,
  input logic [2*NUM_SETS-1:0]     bank_irq
);
  localparam int unsigned LAST = GRP_BASE + GRP_STRIDE * (NUM_SETS - 1);

  p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(GRP_BASE + IX_DIR))
    |=> pin_oe[GRP_W-1:0] == ~$past(bus_wdata));

  p_set_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(GRP_BASE + IX_SET))
    |=> (pin_out[GRP_W-1:0] & $past(bus_wdata)) == $past(bus_wdata));

  p_clr_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(GRP_BASE + IX_CLR))
    |=> (pin_out[GRP_W-1:0] & $past(bus_wdata)) == '0);

  p_out_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> $stable(pin_out) && $stable(pin_oe));

  p_irq_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(IRQ_EN_WRD) && bus_wdata == '0)
    |=> bank_irq == '0);

  p_last_group_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(LAST + IX_DIR))
    |=> pin_oe[GRP_W*NUM_SETS-1 -: GRP_W] == ~$past(bus_wdata));
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.NUM_SETS(NUM_SETS), .ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_we    (bus_we),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .bank_irq  (bank_irq)
);

// File: tb/gpio_bank_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_bank_ctrl_tb_top;
  localparam int AW = 6;
  localparam int G1 = 14;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_rdata;
  logic [63:0]   pin_in = '0;
  logic [63:0]   pin_out, pin_oe;
  logic [3:0]    bank_irq;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  gpio_bank_ctrl #(.NUM_SETS(2), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .bank_irq(bank_irq)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = AW'(a); bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = '0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    bus_addr = AW'(a);
    #1;
    d = bus_rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    @(negedge clk);
    check("R1 oe", pin_oe, 64'h0);
    check("R1 out", pin_out, 64'h0);
    check("R1 irq", 64'(bank_irq), 64'h0);
    rd(4, d);  check("R1 dir", 64'(d), 64'hFFFFFFFF);
    rd(13, d); check("R1 stat", 64'(d), 64'h0);
    rd(9, d);  check("R1 rarm", 64'(d), 64'h0);
    rd(2, d);  check("R1 lineen", 64'(d), 64'h0);
  endtask

  task automatic t_direction;
    logic [31:0] d;
    wr(4, 32'hFFFF0000);
    check("R2 oe", pin_oe, 64'h0000_0000_0000_FFFF);
    rd(4, d); check("R2 dir rd", 64'(d), 64'hFFFF0000);
  endtask

  task automatic t_setclr;
    logic [31:0] d;
    wr(5, 32'h0);
    wr(6, 32'h00F0);
    check("R3 set", pin_out, 64'hF0);
    wr(6, 32'h0F00);
    check("R3 set keeps", pin_out, 64'hFF0);
    wr(7, 32'h0030);
    check("R3 clr", pin_out, 64'hFC0);
    rd(6, d); check("R3 set rd", 64'(d), 64'hFC0);
    rd(7, d); check("R3 clr rd", 64'(d), 64'hFC0);
  endtask

  task automatic t_readback;
    logic [31:0] d;
    @(negedge clk);
    pin_in[7:0] = 8'hA5;
    rd(8, d); check("R4 before", 64'(d), 64'h0);
    settle(1);
    rd(8, d); check("R4 one edge", 64'(d), 64'h0);
    settle(1);
    rd(8, d); check("R4 two edges", 64'(d), 64'hA5);
    pin_in[7:0] = 8'h00;
    settle(3);
  endtask

  task automatic t_enables;
    logic [31:0] d;
    wr(9, 32'h9);
    wr(9, 32'h6);
    rd(10, d); check("R5 rarm", 64'(d), 64'hF);
    wr(10, 32'h3);
    rd(9, d); check("R5 rdis", 64'(d), 64'hC);
    wr(11, 32'hF0);
    wr(12, 32'h30);
    rd(12, d); check("R5 farm", 64'(d), 64'hC0);
    wr(10, 32'hFFFFFFFF);
    wr(12, 32'hFFFFFFFF);
    rd(11, d); check("R5 clear all", 64'(d), 64'h0);
  endtask

  task automatic t_edges;
    logic [31:0] d;
    wr(13, 32'hFFFFFFFF);
    wr(9, 32'h100);
    wr(11, 32'h200);
    @(negedge clk);
    pin_in[10:8] = 3'b111;
    settle(2);
    rd(13, d); check("R6 not yet", 64'(d), 64'h0);
    settle(1);
    rd(13, d); check("R6 rise", 64'(d), 64'h100);
    pin_in[10:8] = 3'b000;
    settle(4);
    rd(13, d); check("R6 fall", 64'(d), 64'h300);
    wr(13, 32'h100);
    rd(13, d); check("R7 w1c", 64'(d), 64'h200);
    wr(13, 32'h200);
    rd(13, d); check("R7 w1c all", 64'(d), 64'h0);
  endtask

  task automatic t_race;
    logic [31:0] d;
    wr(11, 32'h100);
    @(negedge clk);
    pin_in[8] = 1'b1;
    settle(4);
    rd(13, d); check("R7 pre", 64'(d), 64'h100);
    pin_in[8] = 1'b0;
    repeat (2) @(posedge clk);
    wr(13, 32'h100);
    rd(13, d); check("R7 edge wins", 64'(d), 64'h100);
    wr(13, 32'h100);
    rd(13, d); check("R7 cleared", 64'(d), 64'h0);
    wr(10, 32'hFFFFFFFF);
    wr(12, 32'hFFFFFFFF);
  endtask

  task automatic t_bank_irq;
    logic [31:0] d;
    wr(9, 32'h0010_0000);
    wr(G1 + 5, 32'h2);
    @(negedge clk);
    pin_in[20] = 1'b1; pin_in[33] = 1'b1;
    settle(4);
    check("R8 gated", 64'(bank_irq), 64'h0);
    rd(13, d);     check("R8 stat0", 64'(d), 64'h0010_0000);
    rd(G1 + 9, d); check("R10 stat1", 64'(d), 64'h2);
    wr(2, 32'hF);
    check("R8 lines", 64'(bank_irq), 64'h6);
    wr(2, 32'h4);
    check("R8 one line", 64'(bank_irq), 64'h4);
    wr(G1 + 9, 32'h2);
    check("R8 drop", 64'(bank_irq), 64'h0);
    wr(2, 32'hF);
    check("R8 other half", 64'(bank_irq), 64'h2);
    wr(13, 32'hFFFFFFFF);
    wr(2, 32'h0);
    check("R8 off", 64'(bank_irq), 64'h0);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    logic [63:0] o_s, e_s;
    o_s = pin_out; e_s = pin_oe;
    wr(0, 32'hFFFFFFFF);
    wr(1, 32'hFFFFFFFF);
    wr(3, 32'hFFFFFFFF);
    wr(24, 32'hFFFFFFFF);
    wr(63, 32'hFFFFFFFF);
    check("R9 out", pin_out, o_s);
    check("R9 oe", pin_oe, e_s);
    check("R9 irq", 64'(bank_irq), 64'h0);
    rd(0, d);  check("R9 rd0", 64'(d), 64'h0);
    rd(3, d);  check("R9 rd3", 64'(d), 64'h0);
    rd(24, d); check("R9 rd24", 64'(d), 64'h0);
    rd(2, d);  check("R9 lineen", 64'(d), 64'h0);
  endtask

  task automatic t_map;
    wr(G1, 32'hFFFFFFFE);
    check("R10 oe1", pin_oe, {32'h1, 32'h0000FFFF});
    wr(G1 + 2, 32'h1);
    check("R10 out1", pin_out, {32'h1, 32'hFC0});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_direction();
    t_setclr();
    t_readback();
    t_enables();
    t_edges();
    t_race();
    t_bank_irq();
    t_unmapped();
    t_map();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule